// File: doc/BRIEF.md
# Infrared Car Period Classifier

This block identifies which car passes a trackside infrared sensor. Each car flashes its infrared emitter at its own fixed rate. The block timestamps every rising edge of the detector signal with a free-running microsecond counter. It subtracts the previous timestamp from the current one and sorts the interval into one of six narrow windows, each standing for one car number from 1 to 6.

A recognised car number is latched and held for a downstream consumer, which clears it with an acknowledge. A strobe lasting one cycle marks every new non-zero number. While a number is held, further edges are timestamped but not classified.

When the timestamp counter wraps, the stored timestamp is poisoned to all ones. An edge that arrives after a wrap therefore cannot be paired with a timestamp from the previous epoch and produce a false match.

Top module: `ir_car_classifier`

## Requirements
- R1: The timestamp counter (width `TS_W`, default 16) advances by one every `TICK_DIV` clocks (default 50, which gives 1 MHz from a 50 MHz clock). The detector input passes through a two-flop synchroniser, and each rising edge of the synchronised signal captures the counter value.
- R2: When the interval D (current capture minus stored capture, in ticks) lies strictly inside a window, it yields the matching car number. The windows are 54<D<74 for car 1, 118<D<138 for car 2, 186<D<206 for car 3, 246<D<266 for car 4, 310<D<330 for car 5 and 374<D<394 for car 6.
- R3: An interval on or outside every window bound yields no match. It leaves `car_id` unchanged and raises no `new_id`.
- R4: A counter wrap sets the stored timestamp to all ones. The next edge after a wrap is never classified, even if its counter value modulo 2^TS_W would fall inside a window. An edge is evaluated only when the stored timestamp is numerically smaller than the current one.
- R5: Classification happens only while `car_id` is 0. A non-zero `car_id` holds its value until acknowledged, whatever intervals arrive.
- R6: On every rising edge the captured value becomes the stored timestamp, whether or not the edge was evaluated or matched.
- R7: `ack` high at a clock edge clears a held `car_id` to 0. A match that occurs while `car_id` is 0 takes priority over a simultaneous `ack`.
- R8: `new_id` is high for exactly one cycle, in the first cycle in which a new non-zero `car_id` is visible. Otherwise it is low.
- R9: Reset clears `car_id` and `new_id` to 0 and sets the stored timestamp to all ones, so the first edge after reset produces no car number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_in | input | 1 | Raw infrared detector signal, asynchronous |
| ack | input | 1 | Consumer acknowledge; clears the held car number |
| car_id | output | 3 | Held car number, 0 when none |
| new_id | output | 1 | One-cycle strobe when a new car number is latched |

## Verification
The in-line assertions check the following on every cycle:
- a held number stays unchanged until acknowledged;
- an acknowledge clears it;
- the strobe lasts one cycle and coincides with a zero-to-non-zero change;
- the car number never exceeds 6;
- every edge loads the stored timestamp.

Only the bench scenarios can show the following:
- the exact window bounds, including both exclusive edges of every window;
- the counter-wrap invalidation, shown by an edge placed a full wrap plus 64 ticks after its predecessor;
- the effect of the prescaler, shown by a second instance with `TICK_DIV`=4.

// File: rtl/ir_car_classifier.sv
module ir_car_classifier #(
  parameter int TS_W     = 16,
  parameter int TICK_DIV = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ir_in,
  input  logic       ack,
  output logic [2:0] car_id,
  output logic       new_id
);

  logic            tick;
  logic [TS_W-1:0] ts, prev_ts, gap;
  logic [2:0]      sy, hit;
  logic            rise, wrap, eval;

  generate
    if (TICK_DIV > 1) begin : g_pre
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre;
      always_ff @(posedge clk) begin
        if (!rst_n || pre == PW'(TICK_DIV - 1)) pre <= '0;
        else                                    pre <= pre + 1'b1;
      end
      assign tick = (pre == PW'(TICK_DIV - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  function automatic logic [2:0] classify(input logic [TS_W-1:0] d);
    int unsigned v;
    v = 32'(d);
    if      (v > 54  && v < 74)  return 3'd1;
    else if (v > 118 && v < 138) return 3'd2;
    else if (v > 186 && v < 206) return 3'd3;
    else if (v > 246 && v < 266) return 3'd4;
    else if (v > 310 && v < 330) return 3'd5;
    else if (v > 374 && v < 394) return 3'd6;
    else                         return 3'd0;
  endfunction

  assign rise = sy[1] & ~sy[2];
  assign wrap = tick && (ts == '1);
  assign gap  = ts - prev_ts;
  assign hit  = classify(gap);
  assign eval = rise && (car_id == 3'd0) && (prev_ts < ts);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy      <= '0;
      ts      <= '0;
      prev_ts <= '1;
      car_id  <= '0;
      new_id  <= 1'b0;
    end else begin
      sy     <= {sy[1:0], ir_in};
      new_id <= 1'b0;
      if (tick) ts <= ts + 1'b1;
      if (rise)      prev_ts <= ts;
      else if (wrap) prev_ts <= '1;
      if (eval && hit != 3'd0) begin
        car_id <= hit;
        new_id <= 1'b1;
      end else if (ack) begin
        car_id <= 3'd0;
      end
    end
  end

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (car_id != 3'd0 && !ack) |=> car_id == $past(car_id));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (car_id != 3'd0 && ack) |=> car_id == 3'd0);

  // R8
  strobe_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_id |-> car_id != 3'd0);

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_id |=> !new_id);

  // R8
  strobe_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(car_id) == 3'd0 && car_id != 3'd0) |-> new_id);

  // R2
  id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    car_id <= 3'd6);

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> prev_ts == $past(ts));

  // R4
  wrap_poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !rise) |=> prev_ts == '1);

endmodule

// File: tb/ir_car_classifier_tb.sv
module ir_car_classifier_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_in = 1'b0, ack = 1'b0, ir2 = 1'b0;
  logic [2:0] car_id, id2;
  logic new_id, nid2;
  int total = 0, bad = 0, pcnt = 0, p0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ir_car_classifier #(.TS_W(16), .TICK_DIV(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .ack(ack),
    .car_id(car_id), .new_id(new_id));

  ir_car_classifier #(.TS_W(16), .TICK_DIV(4)) u_dut_div (
    .clk(clk), .rst_n(rst_n), .ir_in(ir2), .ack(1'b0),
    .car_id(id2), .new_id(nid2));

  always @(negedge clk) if (new_id) pcnt++;

  localparam int VN = 21;
  localparam int GAPS [VN] = '{20, 54, 55, 64, 73, 74, 118, 119, 137, 186, 196,
                               205, 247, 266, 311, 329, 330, 375, 393, 394, 100};
  localparam int EXPS [VN] = '{0, 0, 1, 1, 1, 0, 0, 2, 2, 0, 3,
                               3, 4, 0, 5, 5, 0, 6, 6, 0, 0};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rise_wait(input int n);
    ir_in = 1'b1;
    repeat (6) @(negedge clk);
    ir_in = 1'b0;
    repeat (n - 6) @(negedge clk);
  endtask

  task automatic ack_pulse();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    check("R9 car_id in reset", car_id, 0);
    check("R9 new_id in reset", new_id, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 prescaled timestamp: 64 clocks = 16 ticks, 256 clocks = 64 ticks
    ir2 = 1'b1; repeat (6) @(negedge clk); ir2 = 1'b0; repeat (58) @(negedge clk);
    ir2 = 1'b1; repeat (6) @(negedge clk); ir2 = 1'b0; repeat (250) @(negedge clk);
    check("R1 16 ticks no match", id2, 0);
    ir2 = 1'b1; repeat (6) @(negedge clk); ir2 = 1'b0; repeat (4) @(negedge clk);
    check("R1 64 ticks gives car 1", id2, 1);

    // R9 first edge after reset yields nothing
    rise_wait(64);
    check("R9 first edge no id", car_id, 0);
    check("R9 no strobe", pcnt, 0);

    // R2 R3 window table
    for (int i = 0; i < VN; i++) begin
      ir_in = 1'b1; repeat (6) @(negedge clk);
      ir_in = 1'b0; repeat (2) @(negedge clk);
      ack_pulse();
      check("R7 ack clears", car_id, 0);
      p0 = pcnt;
      repeat (GAPS[i] - 9) @(negedge clk);
      ir_in = 1'b1; repeat (6) @(negedge clk);
      ir_in = 1'b0; repeat (2) @(negedge clk);
      check($sformatf("R2/R3 gap %0d", GAPS[i]), car_id, EXPS[i]);
      check($sformatf("R8 strobes gap %0d", GAPS[i]), pcnt - p0, EXPS[i] != 0 ? 1 : 0);
      repeat (4) @(negedge clk);
    end

    // R5 hold and R6 capture on unevaluated edge
    ack_pulse();
    rise_wait(64);
    rise_wait(196);
    check("R2 car 1 latched", car_id, 1);
    p0 = pcnt;
    rise_wait(10);
    check("R5 held despite car 3 gap", car_id, 1);
    check("R5 no strobe while held", pcnt - p0, 0);
    ack_pulse();
    check("R7 ack clears held", car_id, 0);
    repeat (53) @(negedge clk);
    rise_wait(10);
    check("R6 interval from held edge", car_id, 1);

    // R4 counter wrap invalidates the stored timestamp
    ack_pulse();
    repeat (20) @(negedge clk);
    rise_wait(65536 + 64);
    rise_wait(64);
    check("R4 edge after wrap not classified", car_id, 0);
    rise_wait(10);
    check("R4 next edge classified", car_id, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule